// File: doc/BRIEF.md
# Port-Steered Micro-op Dispatch Unit

This block sits between an in-order dispatch buffer and a set of execution ports. Each cycle it looks at up to eight renamed micro-ops at the head of the buffer. Each micro-op carries a queue-select code. The block writes as many of them as it can, strictly oldest first, into per-port issue queues. The six non-memory ports each own a private queue. The two load/store ports share one combined queue that has two write lanes and two issue lanes. Direct branches do not pass through here.

An entry waits two clock edges in its queue before it may issue. Each queue then issues its oldest waiting entry into a fixed-latency execution pipe, unless the port's hold input is raised. The shared queue can issue two entries per cycle. At the end of each pipe a per-port completion strobe reports the micro-op's tag.

The dispatch buffer learns how many head slots were taken from `acc_cnt` and advances by that amount. A flush input empties every queue and every pipe at once.

Top module: `uop_port_dispatch`

## Requirements
- R1: `acc_cnt` equals the length of the longest run of slots, starting at slot 0, that are all accepted. Scanning stops at the first slot whose valid bit is low or that cannot be accepted, and no younger slot is taken in that cycle.
- R2: Queue-select codes 0 to 5 name the private queue of port 0 to 5, and codes 6 and 7 both name the shared load/store queue. A private queue takes at most one micro-op per cycle. The shared queue takes at most two.
- R3: A queue accepts only while its occupancy at the start of the cycle, plus what it already took earlier in that cycle, is below QDEPTH. Entries leaving in the same cycle give no credit. `q_full[q]` is high exactly when queue q holds QDEPTH entries.
- R4: An entry written at clock edge k may issue at edge k+2 at the earliest.
- R5: Each queue issues in program order, at most one entry per port per cycle. A private queue whose port has `port_hold` high issues nothing that cycle.
- R6: The oldest eligible load/store entry goes to the lowest-numbered of ports 6 and 7 that is not held. The next-oldest entry issues in the same cycle, on port 7, only if both ports are free and the oldest also issues.
- R7: A micro-op issued at edge k raises `done_vld` for its port, with its tag on `done_tag`, during the cycle that follows edge k+L-1. L is 2 for ports 0 to 2, 4 for port 3, 6 for ports 4 and 5, and 4 for ports 6 and 7.
- R8: While `flush` is high, `acc_cnt` is 0. The next edge empties every queue and every execution pipe.
- R9: A synchronous active-low reset clears all queues and pipes. After it, `acc_cnt` is 0 with no valid input, and all `q_full` and `done_vld` bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| flush | input | 1 | Empty all queues and pipes |
| in_vld | input | DISP_W | Valid bit per buffer head slot, slot 0 oldest |
| in_qsel | input | 3*DISP_W | Queue-select code per slot |
| in_tag | input | TAG_W*DISP_W | Micro-op tag per slot |
| port_hold | input | 8 | Per-port hold, blocks issue to that port |
| acc_cnt | output | $clog2(DISP_W+1) | Head slots accepted this cycle |
| q_full | output | 7 | Queue full flags, index 6 is load/store |
| done_vld | output | 8 | Completion strobe per port |
| done_tag | output | TAG_W*8 | Completing tag per port |

## Verification
Acceptance into a queue and issue out of that same queue fall in the same cycle. Only the start-of-cycle occupancy may decide room, and this is where a design most easily goes wrong. The bench provokes the overlap by holding a port until its queue is full, then releasing the hold while new micro-ops for that queue wait at the head. It also mixes random holds and flushes with random buffer contents. A behavioural queue model predicts, on every cycle, the accepted count, each full flag and each completion, and any slip in the overlap shows up at once as a wrong `acc_cnt` or a shifted completion.

// File: rtl/upd_pkg.sv
// Package: shared constants and per-port properties of the dispatch unit.
// Assumes eight execution ports, the last two of which share queue LSQ.
package upd_pkg;
    localparam int NPORT  = 8;
    localparam int NQ     = 7;
    localparam int LSQ    = 6;
    localparam int QSEL_W = 3;

    // Fixed execution latency of each port.
    function automatic int port_lat(input int p);
        if (p <= 2)      return 2;
        else if (p == 3) return 4;
        else if (p <= 5) return 6;
        else             return 4;
    endfunction

    // Queue named by a select code: codes at or above LSQ go to the shared queue.
    function automatic int queue_of(input logic [QSEL_W-1:0] sel);
        if (int'(sel) >= LSQ) return LSQ;
        else                  return int'(sel);
    endfunction
endpackage

// File: rtl/upd_steer.sv
// Module: upd_steer
// Decides, oldest slot first, which head slots of the dispatch buffer enter
// which queue this cycle. Room comes from start-of-cycle occupancy only.
// Assumes each queue's per-cycle write limit is 1, or 2 for the shared queue.
module upd_steer #(
    parameter int DISP_W = 8,
    parameter int TAG_W  = 8,
    parameter int QDEPTH = 4,
    localparam int CNT_W = $clog2(DISP_W + 1),
    localparam int OCC_W = $clog2(QDEPTH + 1)
) (
    input  logic                                        flush,
    input  logic [DISP_W-1:0]                           in_vld,
    input  logic [DISP_W-1:0][upd_pkg::QSEL_W-1:0]      in_qsel,
    input  logic [DISP_W-1:0][TAG_W-1:0]                in_tag,
    input  logic [upd_pkg::NQ-1:0][OCC_W-1:0]           occ,
    output logic [CNT_W-1:0]                            acc_cnt,
    output logic [upd_pkg::NQ-1:0][1:0]                 push_n,
    output logic [upd_pkg::NQ-1:0][1:0][TAG_W-1:0]      push_tag
);
    int taken [upd_pkg::NQ];
    int acc;
    int qi;
    int lim;
    logic stop;

    // In-order scan of the head slots, stopping at the first refusal.
    always_comb begin
        acc      = 0;
        stop     = flush;
        qi       = 0;
        lim      = 0;
        push_tag = '0;
        for (int q = 0; q < upd_pkg::NQ; q++) taken[q] = 0;
        for (int i = 0; i < DISP_W; i++) begin
            if (!stop) begin
                if (!in_vld[i]) begin
                    stop = 1'b1;
                end else begin
                    qi  = upd_pkg::queue_of(in_qsel[i]);
                    lim = (qi == upd_pkg::LSQ) ? 2 : 1;
                    if (taken[qi] < lim && taken[qi] + int'(occ[qi]) < QDEPTH) begin
                        push_tag[qi][taken[qi]] = in_tag[i];
                        taken[qi] = taken[qi] + 1;
                        acc       = acc + 1;
                    end else begin
                        stop = 1'b1;
                    end
                end
            end
        end
        for (int q = 0; q < upd_pkg::NQ; q++) push_n[q] = 2'(taken[q]);
        acc_cnt = CNT_W'(acc);
    end
endmodule

// File: rtl/upd_port_queue.sv
// Module: upd_port_queue
// Circular issue queue with WAYS write and issue lanes (1 or 2). An entry
// becomes eligible one edge after it is written and issues at the next.
// Assumes DEPTH is a power of two, at least 2, and that the writer never
// exceeds the free space.
module upd_port_queue #(
    parameter int TAG_W = 8,
    parameter int DEPTH = 4,
    parameter int WAYS  = 1,
    localparam int PW    = $clog2(DEPTH),
    localparam int OCC_W = $clog2(DEPTH + 1)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   flush,
    input  logic [1:0]             push_n,
    input  logic [1:0][TAG_W-1:0]  push_tag,
    input  logic [1:0]             iss_room,
    output logic [OCC_W-1:0]       occ,
    output logic                   full,
    output logic [1:0]             iss_v,
    output logic [1:0][TAG_W-1:0]  iss_tag
);
    logic [TAG_W-1:0] mem [DEPTH];
    logic [DEPTH-1:0] seas;
    logic [PW-1:0]    rd, wr, rd1, wr1;
    logic [OCC_W-1:0] cnt;
    logic             iss0, iss1;
    logic [1:0]       pop_n;

    assign rd1  = rd + PW'(1);
    assign wr1  = wr + PW'(1);
    assign occ  = cnt;
    assign full = (int'(cnt) == DEPTH);

    // Oldest entry issues when seasoned and a port is free.
    assign iss0 = (cnt != '0) && seas[rd] && (iss_room != 2'd0);

    generate
        if (WAYS == 2) begin : g_dual
            // Second-oldest issues only beside the oldest and with two free ports.
            assign iss1 = iss0 && (iss_room == 2'd2) && (int'(cnt) >= 2) && seas[rd1];
        end else begin : g_single
            assign iss1 = 1'b0;
        end
    endgenerate

    assign iss_v      = {iss1, iss0};
    assign iss_tag[0] = mem[rd];
    assign iss_tag[1] = mem[rd1];
    assign pop_n      = 2'(int'(iss0) + int'(iss1));

    // Pointer, count and seasoning state.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            rd   <= '0;
            wr   <= '0;
            cnt  <= '0;
            seas <= '0;
        end else begin
            seas <= '1;
            if (push_n != 2'd0) seas[wr]  <= 1'b0;
            if (push_n == 2'd2) seas[wr1] <= 1'b0;
            wr  <= PW'(int'(wr) + int'(push_n));
            rd  <= PW'(int'(rd) + int'(pop_n));
            cnt <= OCC_W'(int'(cnt) + int'(push_n) - int'(pop_n));
        end
    end

    // Tag storage writes.
    always_ff @(posedge clk) begin
        if (push_n != 2'd0) mem[wr]  <= push_tag[0];
        if (push_n == 2'd2) mem[wr1] <= push_tag[1];
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (push_n != 2'd0) |-> (int'(cnt) + int'(push_n) <= DEPTH)); // R3
    AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (cnt == '0)); // R8
    AST_FRESH_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == '0 && push_n != 2'd0 && !flush) |=> (iss_v == 2'b00)); // R4
endmodule

// File: rtl/upd_exec_pipe.sv
// Module: upd_exec_pipe
// Fixed-latency execution model: a valid/tag shift line LAT stages long.
// Assumes LAT is at least 2 and one issue per cycle at most.
module upd_exec_pipe #(
    parameter int TAG_W = 8,
    parameter int LAT   = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             in_v,
    input  logic [TAG_W-1:0] in_tag,
    output logic             out_v,
    output logic [TAG_W-1:0] out_tag
);
    logic [LAT-1:0]            v;
    logic [LAT-1:0][TAG_W-1:0] t;

    // Valid bits advance one stage per cycle; flush or reset drains them.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) v <= '0;
        else                 v <= {v[LAT-2:0], in_v};
    end

    // Tags follow their valid bits.
    always_ff @(posedge clk) begin
        t[0] <= in_tag;
        for (int s = 1; s < LAT; s++) t[s] <= t[s-1];
    end

    assign out_v   = v[LAT-1];
    assign out_tag = t[LAT-1];

    AST_PIPE_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        (v[1] && !flush) |=> v[2 % LAT] || (LAT == 2)); // R7
endmodule

// File: rtl/uop_port_dispatch.sv
// Module: uop_port_dispatch (top)
// Steers up to DISP_W micro-ops per cycle into six private queues and one
// shared load/store queue, issues them to eight ports and reports completion
// after a fixed per-port latency. Assumes the buffer presents valid slots
// from slot 0 and advances by acc_cnt.
module uop_port_dispatch #(
    parameter int DISP_W = 8,
    parameter int TAG_W  = 8,
    parameter int QDEPTH = 4,
    localparam int CNT_W = $clog2(DISP_W + 1),
    localparam int OCC_W = $clog2(QDEPTH + 1)
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             flush,
    input  logic [DISP_W-1:0]                in_vld,
    input  logic [DISP_W*3-1:0]              in_qsel,
    input  logic [DISP_W*TAG_W-1:0]          in_tag,
    input  logic [7:0]                       port_hold,
    output logic [CNT_W-1:0]                 acc_cnt,
    output logic [6:0]                       q_full,
    output logic [7:0]                       done_vld,
    output logic [8*TAG_W-1:0]               done_tag
);
    import upd_pkg::*;

    logic [NQ-1:0][OCC_W-1:0]      occ;
    logic [NQ-1:0][1:0]            push_n;
    logic [NQ-1:0][1:0][TAG_W-1:0] push_tag;
    logic [NQ-1:0][1:0]            iss_room;
    logic [NQ-1:0][1:0]            qv;
    logic [NQ-1:0][1:0][TAG_W-1:0] qt;
    logic [NPORT-1:0]              port_iv;
    logic [NPORT-1:0][TAG_W-1:0]   port_it;

    upd_steer #(.DISP_W(DISP_W), .TAG_W(TAG_W), .QDEPTH(QDEPTH)) u_steer (
        .flush    (flush),
        .in_vld   (in_vld),
        .in_qsel  (in_qsel),
        .in_tag   (in_tag),
        .occ      (occ),
        .acc_cnt  (acc_cnt),
        .push_n   (push_n),
        .push_tag (push_tag)
    );

    generate
        for (genvar q = 0; q < NQ; q++) begin : g_q
            localparam int WAYS = (q == LSQ) ? 2 : 1;
            upd_port_queue #(.TAG_W(TAG_W), .DEPTH(QDEPTH), .WAYS(WAYS)) u_q (
                .clk      (clk),
                .rst_n    (rst_n),
                .flush    (flush),
                .push_n   (push_n[q]),
                .push_tag (push_tag[q]),
                .iss_room (iss_room[q]),
                .occ      (occ[q]),
                .full     (q_full[q]),
                .iss_v    (qv[q]),
                .iss_tag  (qt[q])
            );
        end

        for (genvar p = 0; p < LSQ; p++) begin : g_priv
            // Private port: issue room is simply its own hold.
            assign iss_room[p] = {1'b0, !port_hold[p]};
            assign port_iv[p]  = qv[p][0];
            assign port_it[p]  = qt[p][0];
        end
    endgenerate

    // Shared queue: oldest to the first free of ports 6/7, next to port 7.
    always_comb begin
        iss_room[LSQ] = 2'(int'(!port_hold[6]) + int'(!port_hold[7]));
        if (port_hold[6]) begin
            port_iv[6] = 1'b0;
            port_it[6] = qt[LSQ][0];
            port_iv[7] = qv[LSQ][0];
            port_it[7] = qt[LSQ][0];
        end else begin
            port_iv[6] = qv[LSQ][0];
            port_it[6] = qt[LSQ][0];
            port_iv[7] = qv[LSQ][1];
            port_it[7] = qt[LSQ][1];
        end
    end

    generate
        for (genvar p = 0; p < NPORT; p++) begin : g_pipe
            upd_exec_pipe #(.TAG_W(TAG_W), .LAT(port_lat(p))) u_pipe (
                .clk     (clk),
                .rst_n   (rst_n),
                .flush   (flush),
                .in_v    (port_iv[p]),
                .in_tag  (port_it[p]),
                .out_v   (done_vld[p]),
                .out_tag (done_tag[p*TAG_W +: TAG_W])
            );
        end
    endgenerate

    AST_ACC_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        int'(acc_cnt) <= $countones(in_vld)); // R1
    AST_FULL_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld[0] && q_full[queue_of(in_qsel[2:0])]) |-> (acc_cnt == '0)); // R3
    AST_HOLD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        port_hold[0] |-> !port_iv[0]); // R5
    AST_LS_SECOND: assert property (@(posedge clk) disable iff (!rst_n)
        (port_iv[7] && !port_hold[6]) |-> port_iv[6]); // R6
    AST_ALU_LAT: assert property (@(posedge clk) disable iff (!rst_n)
        done_vld[0] |-> $past(port_iv[0], 2)); // R7
endmodule

// File: tb/uop_port_dispatch_test.sv
// Bench: behavioural reference model of queues and pipes, compared every cycle.
module uop_port_dispatch_test;
    localparam int CLK_P = 10;
    localparam int DEPTH = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        flush = 1'b0;
    logic [7:0]  in_vld = '0;
    logic [23:0] in_qsel = '0;
    logic [63:0] in_tag = '0;
    logic [7:0]  port_hold = '0;
    logic [3:0]  acc_cnt;
    logic [6:0]  q_full;
    logic [7:0]  done_vld;
    logic [63:0] done_tag;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    int mq_tag [7][$];
    int mq_edge[7][$];
    int pv[8][6];
    int pt[8][6];
    int edge_n = 0;
    int next_tag = 1;

    always #(CLK_P/2) clk = ~clk;

    uop_port_dispatch uut (
        .clk(clk), .rst_n(rst_n), .flush(flush), .in_vld(in_vld),
        .in_qsel(in_qsel), .in_tag(in_tag), .port_hold(port_hold),
        .acc_cnt(acc_cnt), .q_full(q_full), .done_vld(done_vld), .done_tag(done_tag)
    );

    // Latency per port, from R7.
    function automatic int lat_p(int p);
        if (p < 3) return 2;
        if (p == 3) return 4;
        if (p < 6) return 6;
        return 4;
    endfunction

    function automatic int qof(int sel);
        return (sel >= 6) ? 6 : sel;   // R2 encoding
    endfunction

    task automatic check(bit ok, string req, int got, int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s got=%0d exp=%0d at t=%0t", req, got, exp, $time);
        end
    endtask

    task automatic model_clear();
        for (int q = 0; q < 7; q++) begin
            mq_tag[q].delete();
            mq_edge[q].delete();
        end
        for (int p = 0; p < 8; p++)
            for (int s = 0; s < 6; s++) begin
                pv[p][s] = 0;
                pt[p][s] = 0;
            end
    endtask

    // Compare current outputs with the model, then advance the model past the next edge.
    task automatic tick();
        int tk[7];
        int acc;
        int pq[8];
        int ptg[8];
        int nxt;
        int iv[8];
        int it[8];
        int sel;
        int q;
        int lim;
        #1;
        nxt = edge_n + 1;
        acc = 0;
        for (int k = 0; k < 7; k++) tk[k] = 0;
        // R1 R2 R3 R8: in-order acceptance
        if (!flush) begin
            for (int i = 0; i < 8; i++) begin
                if (!in_vld[i]) break;
                sel = int'(in_qsel[i*3 +: 3]);
                q   = qof(sel);
                lim = (q == 6) ? 2 : 1;
                if (tk[q] < lim && mq_tag[q].size() + tk[q] < DEPTH) begin
                    pq[acc]  = q;
                    ptg[acc] = int'(in_tag[i*8 +: 8]);
                    tk[q]++;
                    acc++;
                end else break;
            end
        end
        check(int'(acc_cnt) == acc, "R1 acc_cnt", int'(acc_cnt), acc);
        for (int k = 0; k < 7; k++) begin
            int ef;
            ef = (mq_tag[k].size() == DEPTH) ? 1 : 0;
            check(int'(q_full[k]) == ef, "R3 q_full", int'(q_full[k]), ef);
        end
        // R4 R5 R6 R7: completion per port
        for (int p = 0; p < 8; p++) begin
            int l;
            l = lat_p(p);
            check(int'(done_vld[p]) == pv[p][l-1], "R7 done_vld", int'(done_vld[p]), pv[p][l-1]);
            if (pv[p][l-1] != 0)
                check(int'(done_tag[p*8 +: 8]) == pt[p][l-1], "R5 done_tag",
                      int'(done_tag[p*8 +: 8]), pt[p][l-1]);
        end
        if (flush) begin
            model_clear();   // R8
        end else begin
            for (int p = 0; p < 8; p++) begin
                iv[p] = 0;
                it[p] = 0;
            end
            for (int k = 0; k < 6; k++) begin
                if (!port_hold[k] && mq_tag[k].size() > 0 && mq_edge[k][0] + 2 <= nxt) begin
                    iv[k] = 1;
                    it[k] = mq_tag[k].pop_front();
                    void'(mq_edge[k].pop_front());
                end
            end
            begin
                int room;
                int firstp;
                room   = (port_hold[6] ? 0 : 1) + (port_hold[7] ? 0 : 1);
                firstp = port_hold[6] ? 7 : 6;
                if (room > 0 && mq_tag[6].size() > 0 && mq_edge[6][0] + 2 <= nxt) begin
                    iv[firstp] = 1;
                    it[firstp] = mq_tag[6].pop_front();
                    void'(mq_edge[6].pop_front());
                    if (room == 2 && mq_tag[6].size() > 0 && mq_edge[6][0] + 2 <= nxt) begin
                        iv[7] = 1;
                        it[7] = mq_tag[6].pop_front();
                        void'(mq_edge[6].pop_front());
                    end
                end
            end
            for (int p = 0; p < 8; p++) begin
                for (int s = 5; s > 0; s--) begin
                    pv[p][s] = pv[p][s-1];
                    pt[p][s] = pt[p][s-1];
                end
                pv[p][0] = iv[p];
                pt[p][0] = it[p];
            end
            for (int a = 0; a < acc; a++) begin
                mq_tag[pq[a]].push_back(ptg[a]);
                mq_edge[pq[a]].push_back(nxt);
            end
        end
        edge_n = nxt;
        @(negedge clk);
    endtask

    task automatic clear_slots();
        in_vld = '0;
        in_qsel = '0;
        in_tag = '0;
    endtask

    task automatic set_slot(int i, int sel);
        in_vld[i]        = 1'b1;
        in_qsel[i*3 +: 3] = 3'(sel);
        in_tag[i*8 +: 8]  = 8'(next_tag);
        next_tag = (next_tag % 250) + 1;
    endtask

    task automatic idle(int n);
        clear_slots();
        for (int k = 0; k < n; k++) tick();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            bad++;
            total++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        model_clear();
        repeat (3) @(negedge clk);
        // R9: reset state visible while reset is held
        check(acc_cnt == '0, "R9 acc_cnt", int'(acc_cnt), 0);
        check(q_full == '0, "R9 q_full", int'(q_full), 0);
        check(done_vld == '0, "R9 done_vld", int'(done_vld), 0);
        rst_n = 1'b1;

        // Single ALU op: latency 2 on port 0 (R4, R7)
        set_slot(0, 0);
        tick();
        idle(8);

        // Full eight-wide dispatch, one per port, code 7 also load/store (R2)
        for (int i = 0; i < 8; i++) set_slot(i, i);
        tick();
        idle(10);

        // Two ops to one private queue: second and younger stall (R1, R2)
        set_slot(0, 1); set_slot(1, 1); set_slot(2, 2);
        tick();
        set_slot(0, 1); set_slot(1, 2);
        tick();
        idle(6);

        // Invalid slot ends the scan even with valid slots behind it (R1)
        set_slot(0, 3); set_slot(2, 4);
        in_vld[1] = 1'b0;
        tick();
        idle(10);

        // Fill MUL queue under hold, then stall head and younger (R3, R5)
        port_hold[3] = 1'b1;
        for (int k = 0; k < 5; k++) begin
            clear_slots();
            set_slot(0, 3); set_slot(1, 0);
            tick();
        end
        // Release hold while new work waits: issue and accept in one cycle (R3)
        port_hold[3] = 1'b0;
        clear_slots();
        set_slot(0, 3);
        tick();
        tick();
        idle(12);

        // Load/store with port 6 held: oldest goes to port 7 (R6)
        port_hold[6] = 1'b1;
        set_slot(0, 6); set_slot(1, 7); set_slot(2, 6);
        tick();
        idle(8);
        port_hold[6] = 1'b0;
        // Port 7 held: only one per cycle on port 6 (R6)
        port_hold[7] = 1'b1;
        set_slot(0, 6); set_slot(1, 6);
        tick();
        idle(8);
        port_hold = '0;

        // Flush with queues and pipes busy (R8)
        port_hold[4] = 1'b1;
        for (int k = 0; k < 3; k++) begin
            clear_slots();
            set_slot(0, 4); set_slot(1, 5); set_slot(2, 6);
            tick();
        end
        flush = 1'b1;
        set_slot(0, 0);
        tick();
        flush = 1'b0;
        port_hold = '0;
        idle(10);

        // Random traffic with holds and flushes (all requirements)
        for (int c = 0; c < 3000; c++) begin
            int n;
            clear_slots();
            n = int'($urandom_range(0, 8));
            for (int i = 0; i < n; i++) set_slot(i, int'($urandom_range(0, 7)));
            if (n > 0 && $urandom_range(0, 5) == 0) in_vld[$urandom_range(0, n-1)] = 1'b0;
            port_hold = 8'($urandom) & 8'($urandom);
            flush = ($urandom_range(0, 60) == 0);
            tick();
        end
        flush = 1'b0;
        port_hold = '0;
        idle(10);

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule